// File: doc/BRIEF.md
# Four-phase control-register bus master

This block drives a narrow configuration bus on which every exchange is a full four-phase strobe/acknowledge handshake. A 16-bit word port carries either a register address or a data word, and the strobe that goes high says which of the two it is. The other strobes ask for a read or commit a write. The slave answers on one acknowledge line and, for reads, on a 16-bit return word.

A client issues one command at a time on a plain request port. The command is a read, a write or a read-modify-write. The block breaks each command into the phases it needs, runs them in a fixed order and then reports completion with a single-cycle done pulse. It returns the read data and flags an error if the slave stops answering. Every acknowledge wait is bounded by a cycle budget. When the budget runs out, the command is abandoned at once and none of its later phases run.

Top module: `crbus_master`

## Requirements
- R1: A command is taken only in a cycle where `ready` and `req_valid` are both high. `req_op` is encoded as 2'b00 read, 2'b01 write and 2'b10 read-modify-write, and 2'b11 behaves exactly like a read.
- R2: After reset, `ready` is high and `done`, `err`, `rdata`, `cr_din` and all four strobes are low. At no time is more than one strobe high.
- R3: An address or data-capture phase drives its word on `cr_din` with all strobes low for at least `SETTLE_CYC` cycles (default 2). Only then does the matching capture strobe rise, and the word stays unchanged while that strobe is high.
- R4: A strobe stays high until `cr_ack` is seen high, then drops. The phase is complete only once `cr_ack` is seen low again. A strobe never falls while the slave has not acknowledged, except on a timeout.
- R5: A read runs an address phase, then holds `cr_din` at zero with all strobes low for one cycle, then raises `cr_rd`. `cr_dout` is sampled while `cr_ack` is high, and that value appears on `rdata` when `done` pulses.
- R6: A write runs an address phase, then a data-capture phase under the R3 settle rule, then a commit phase. In the commit phase `cr_wr` rises with the data word still on `cr_din`. The slave therefore stores the data at the captured address.
- R7: A read-modify-write reads the target and then writes back `(old & ~req_mask) | req_wdata` to the same address. `rdata` returns the old value.
- R8: If any acknowledge wait lasts `TMO_CYC` cycles (default 200), all strobes drop and `cr_din` returns to zero. `done` then pulses with `err` high, and no later phase of that command is started. The next command then runs normally.
- R9: Request inputs presented while `ready` is low are ignored. No second command is started from them and no extra `done` pulse is produced.
- R10: `done` is high for exactly one cycle per accepted command. `err` is high only together with `done`. `rdata` keeps its last read value across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command present |
| req_op | input | 2 | Command kind (see R1) |
| req_addr | input | 16 | Target register address |
| req_wdata | input | 16 | Write data, or OR value for read-modify-write |
| req_mask | input | 16 | Bits cleared before the OR in read-modify-write |
| ready | output | 1 | Idle, a command may be presented |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command aborted on timeout, valid with done |
| rdata | output | 16 | Data from the last read |
| cr_din | output | 16 | Address or data word towards the slave |
| cr_cap_addr | output | 1 | Capture-address strobe |
| cr_cap_data | output | 1 | Capture-data strobe |
| cr_rd | output | 1 | Read strobe |
| cr_wr | output | 1 | Write-commit strobe |
| cr_dout | input | 16 | Read word from the slave |
| cr_ack | input | 1 | Slave acknowledge |

## Verification
The assertions assume that the slave raises `cr_ack` only in answer to a strobe and lowers it only after the strobe has fallen. They also assume that `cr_dout` is steady while the acknowledge of a read is high. The bench's responder model follows this, with zero to three cycles of random latency on each edge. It breaks the rule only in the two stuck-acknowledge modes, and those are switched on solely to provoke the timeout. Request fields are changed only at the falling clock edge, and the bench holds `req_valid` during busy cycles only to show that the block ignores it.

// File: rtl/crbus_pkg.sv
package crbus_pkg;

    localparam int unsigned CR_W = 16;

    typedef logic [CR_W-1:0] cr_word_t;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_RMW   = 2'b10,
        OP_READB = 2'b11
    } cr_op_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_DATA,
        PH_READ,
        PH_COMMIT
    } cr_phase_e;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_SETTLE,
        PS_HIGH,
        PS_LOW
    } cr_pstate_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ADDR,
        SQ_READ,
        SQ_ADDR2,
        SQ_DATA,
        SQ_COMMIT
    } cr_seq_e;

    typedef struct packed {
        logic cap_addr;
        logic cap_data;
        logic rd;
        logic wr;
    } cr_strobe_t;

    typedef struct packed {
        cr_op_e   op;
        cr_word_t addr;
        cr_word_t wdata;
        cr_word_t mask;
    } cr_req_t;

    function automatic cr_word_t rmw_merge(cr_word_t old, cr_word_t mask, cr_word_t val);
        return (old & ~mask) | val;
    endfunction

    function automatic cr_strobe_t strobe_for(cr_phase_e k);
        cr_strobe_t s;
        s = '0;
        case (k)
            PH_ADDR:   s.cap_addr = 1'b1;
            PH_DATA:   s.cap_data = 1'b1;
            PH_READ:   s.rd       = 1'b1;
            default:   s.wr       = 1'b1;
        endcase
        return s;
    endfunction

    // Capture phases settle for the full count, read and commit for one cycle.
    function automatic int unsigned settle_len(cr_phase_e k, int unsigned n);
        return (k == PH_ADDR || k == PH_DATA) ? n : 1;
    endfunction

    function automatic cr_seq_e next_step(cr_seq_e s, cr_op_e op);
        case (s)
            SQ_ADDR:  return (op == OP_WRITE) ? SQ_DATA : SQ_READ;
            SQ_READ:  return (op == OP_RMW) ? SQ_ADDR2 : SQ_IDLE;
            SQ_ADDR2: return SQ_DATA;
            SQ_DATA:  return SQ_COMMIT;
            default:  return SQ_IDLE;
        endcase
    endfunction

    function automatic cr_phase_e phase_of(cr_seq_e s);
        case (s)
            SQ_READ:   return PH_READ;
            SQ_DATA:   return PH_DATA;
            SQ_COMMIT: return PH_COMMIT;
            default:   return PH_ADDR;
        endcase
    endfunction

endpackage

// File: rtl/crbus_phase.sv
module crbus_phase
    import crbus_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 2,
    parameter int unsigned TMO_CYC    = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  cr_phase_e  kind,
    input  cr_word_t   word,
    input  logic       ack,
    input  cr_word_t   dout,
    output cr_word_t   din,
    output cr_strobe_t stb,
    output logic       fin,
    output logic       fin_err,
    output cr_word_t   rd_word
);
    localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
    localparam int unsigned TW = $clog2(TMO_CYC + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TMO_CYC - 1);

    cr_pstate_e    st;
    cr_phase_e     kind_q;
    logic [SW-1:0] scnt;
    logic [TW-1:0] tcnt;
    logic          any_stb;

    assign any_stb = |stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= PS_IDLE;
            kind_q  <= PH_ADDR;
            din     <= '0;
            stb     <= '0;
            fin     <= 1'b0;
            fin_err <= 1'b0;
            scnt    <= '0;
            tcnt    <= '0;
            rd_word <= '0;
        end else begin
            fin     <= 1'b0;
            fin_err <= 1'b0;
            case (st)
                PS_IDLE: begin
                    if (start) begin
                        kind_q <= kind;
                        din    <= (kind == PH_READ) ? '0 : word;
                        scnt   <= SW'(settle_len(kind, SETTLE_CYC));
                        st     <= PS_SETTLE;
                    end
                end
                PS_SETTLE: begin
                    if (scnt <= SW'(1)) begin
                        stb  <= strobe_for(kind_q);
                        tcnt <= '0;
                        st   <= PS_HIGH;
                    end else begin
                        scnt <= scnt - SW'(1);
                    end
                end
                PS_HIGH: begin
                    if (ack) begin
                        stb  <= '0;
                        tcnt <= '0;
                        st   <= PS_LOW;
                        if (kind_q == PH_READ) rd_word <= dout;
                    end else if (tcnt == T_LAST) begin
                        stb     <= '0;
                        din     <= '0;
                        fin     <= 1'b1;
                        fin_err <= 1'b1;
                        st      <= PS_IDLE;
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
                default: begin
                    if (!ack) begin
                        din <= '0;
                        fin <= 1'b1;
                        st  <= PS_IDLE;
                    end else if (tcnt == T_LAST) begin
                        din     <= '0;
                        fin     <= 1'b1;
                        fin_err <= 1'b1;
                        st      <= PS_IDLE;
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
            endcase
        end
    end

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb));

    a_r3_settled_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(any_stb) |-> ($stable(din) && $past(st) == PS_SETTLE));

    a_r4_word_held: assert property (@(posedge clk) disable iff (rst)
        (any_stb && $past(any_stb)) |-> $stable(din));

    a_r4_wait_ack: assert property (@(posedge clk) disable iff (rst)
        (any_stb && !ack && tcnt != T_LAST) |=> any_stb);

    a_r4_release_seen: assert property (@(posedge clk) disable iff (rst)
        (fin && !fin_err) |-> !$past(ack));

    a_r5_read_zero: assert property (@(posedge clk) disable iff (rst)
        stb.rd |-> (din == '0));

    a_r8_abort_quiet: assert property (@(posedge clk) disable iff (rst)
        fin_err |-> (stb == '0 && din == '0));

endmodule

// File: rtl/crbus_seq.sv
module crbus_seq
    import crbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  cr_req_t   req,
    output logic      ready,
    output logic      done,
    output logic      err,
    output cr_word_t  rdata,
    output logic      pstart,
    output cr_phase_e pkind,
    output cr_word_t  pword,
    input  logic      pfin,
    input  logic      pfin_err,
    input  cr_word_t  prd_word
);
    cr_seq_e  st;
    cr_seq_e  nxt;
    cr_req_t  req_q;
    cr_word_t wword;
    logic     launch;

    assign ready  = (st == SQ_IDLE);
    assign nxt    = next_step(st, req_q.op);
    assign pstart = launch;
    assign pkind  = phase_of(st);
    assign pword  = (st == SQ_ADDR || st == SQ_ADDR2) ? req_q.addr : wword;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            req_q  <= '0;
            wword  <= '0;
            launch <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
            rdata  <= '0;
        end else begin
            done   <= 1'b0;
            err    <= 1'b0;
            launch <= 1'b0;
            if (st == SQ_IDLE) begin
                if (req_valid) begin
                    req_q  <= req;
                    wword  <= req.wdata;
                    st     <= SQ_ADDR;
                    launch <= 1'b1;
                end
            end else if (pfin) begin
                if (pfin_err) begin
                    done <= 1'b1;
                    err  <= 1'b1;
                    st   <= SQ_IDLE;
                end else begin
                    if (st == SQ_READ) begin
                        rdata <= prd_word;
                        wword <= rmw_merge(prd_word, req_q.mask, req_q.wdata);
                    end
                    if (nxt == SQ_IDLE) done <= 1'b1;
                    else                launch <= 1'b1;
                    st <= nxt;
                end
            end
        end
    end

    a_r10_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> ready);

    a_r9_hold_cmd: assert property (@(posedge clk) disable iff (rst)
        (!ready && $past(!ready)) |-> $stable(req_q));

    a_r8_no_next_phase: assert property (@(posedge clk) disable iff (rst)
        (pfin && pfin_err) |=> !pstart);

endmodule

// File: rtl/crbus_master.sv
module crbus_master
    import crbus_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 2,
    parameter int unsigned TMO_CYC    = 200
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic [15:0] req_mask,
    output logic        ready,
    output logic        done,
    output logic        err,
    output logic [15:0] rdata,
    output logic [15:0] cr_din,
    output logic        cr_cap_addr,
    output logic        cr_cap_data,
    output logic        cr_rd,
    output logic        cr_wr,
    input  logic [15:0] cr_dout,
    input  logic        cr_ack
);
    cr_req_t    req;
    cr_strobe_t stb;
    logic       pstart, pfin, pfin_err;
    cr_phase_e  pkind;
    cr_word_t   pword, prd_word;

    assign req = '{op: cr_op_e'(req_op), addr: req_addr, wdata: req_wdata, mask: req_mask};

    crbus_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req      (req),
        .ready    (ready),
        .done     (done),
        .err      (err),
        .rdata    (rdata),
        .pstart   (pstart),
        .pkind    (pkind),
        .pword    (pword),
        .pfin     (pfin),
        .pfin_err (pfin_err),
        .prd_word (prd_word)
    );

    crbus_phase #(
        .SETTLE_CYC(SETTLE_CYC),
        .TMO_CYC   (TMO_CYC)
    ) u_phase (
        .clk    (clk),
        .rst    (rst),
        .start  (pstart),
        .kind   (pkind),
        .word   (pword),
        .ack    (cr_ack),
        .dout   (cr_dout),
        .din    (cr_din),
        .stb    (stb),
        .fin    (pfin),
        .fin_err(pfin_err),
        .rd_word(prd_word)
    );

    assign cr_cap_addr = stb.cap_addr;
    assign cr_cap_data = stb.cap_data;
    assign cr_rd       = stb.rd;
    assign cr_wr       = stb.wr;

endmodule

// File: tb/tb_crbus_master.sv
module tb_crbus_master;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE = 2;
    localparam int TMO = 200;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [15:0] req_addr = '0, req_wdata = '0, req_mask = '0;
    logic        ready, done, err;
    logic [15:0] rdata, cr_din;
    logic        cr_cap_addr, cr_cap_data, cr_rd, cr_wr;
    logic [15:0] cr_dout = '0;
    logic        cr_ack = 1'b0;

    crbus_master #(.SETTLE_CYC(SETTLE), .TMO_CYC(TMO)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .ready(ready), .done(done), .err(err), .rdata(rdata),
        .cr_din(cr_din), .cr_cap_addr(cr_cap_addr), .cr_cap_data(cr_cap_data),
        .cr_rd(cr_rd), .cr_wr(cr_wr), .cr_dout(cr_dout), .cr_ack(cr_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Slave model: register array indexed by the low address nibble.
    logic [15:0] mem [16];
    logic [15:0] shadow [16];
    logic [15:0] sl_addr = '0, sl_data = '0, prev_din = '0;
    logic [3:0]  prev_s = '0;
    int dly = 0, quiet = 0, mode = 0;
    int rise_ca = 0, rise_cd = 0, rise_rd = 0, rise_wr = 0;
    int settle_bad = 0, proto_bad = 0, done_cnt = 0;

    always @(negedge clk) begin
        logic [3:0] s;
        int need;
        s = {cr_cap_addr, cr_cap_data, cr_rd, cr_wr};
        if (rst) begin
            cr_ack = 1'b0; dly = 0; quiet = 0; prev_s = '0; prev_din = '0;
        end else begin
            if (done) done_cnt++;
            if (s != 0 && prev_s == 0) begin
                if (s[3]) rise_ca++;
                if (s[2]) rise_cd++;
                if (s[1]) rise_rd++;
                if (s[0]) rise_wr++;
                need = (s[3] || s[2]) ? SETTLE : 1;
                if (quiet < need) settle_bad++;
                if (cr_din != prev_din) settle_bad++;
                if (s[1] && cr_din != 16'h0) settle_bad++;
            end
            if (s != 0 && prev_s != 0 && cr_din != prev_din) proto_bad++;
            if (s == 0 && prev_s != 0 && !cr_ack && mode == 0) proto_bad++;
            if (s == 0) quiet = (cr_din == prev_din) ? quiet + 1 : 1;
            else        quiet = 0;
            prev_s = s; prev_din = cr_din;
            if (!cr_ack) begin
                if (s != 0 && mode != 1) begin
                    if (dly > 0) dly--;
                    else begin
                        if (s[3]) sl_addr = cr_din;
                        if (s[2]) sl_data = cr_din;
                        if (s[1]) cr_dout = mem[sl_addr[3:0]];
                        if (s[0]) begin
                            if (cr_din != sl_data) proto_bad++;
                            mem[sl_addr[3:0]] = sl_data;
                        end
                        cr_ack = 1'b1;
                        dly = int'($urandom % 4);
                    end
                end
            end else if (s == 0 && mode != 2) begin
                if (dly > 0) dly--;
                else begin
                    cr_ack = 1'b0;
                    dly = int'($urandom % 4);
                end
            end
        end
    end

    task automatic run(input logic [1:0] op, input logic [15:0] a, input logic [15:0] d,
                       input logic [15:0] m, output int cyc);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // op, address, data, mask
    localparam logic [49:0] VEC [0:7] = '{
        {2'b01, 16'h1003, 16'h1234, 16'h0000},
        {2'b00, 16'h1003, 16'h0000, 16'h0000},
        {2'b00, 16'h2007, 16'h0000, 16'h0000},
        {2'b10, 16'h2007, 16'h0055, 16'hFF00},
        {2'b00, 16'h2007, 16'h0000, 16'h0000},
        {2'b11, 16'h1003, 16'h0000, 16'h0000},
        {2'b01, 16'h300F, 16'hFFFF, 16'h0000},
        {2'b10, 16'h300F, 16'h0100, 16'h00F0}
    };

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc, d0, ca0, cd0, rd0;
        logic [15:0] last_rd, old, e;
        for (int i = 0; i < 16; i++) begin
            mem[i] = 16'hA000 + 16'(i);
            shadow[i] = 16'hA000 + 16'(i);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: reset state
        chk(ready == 1'b1, "R2 ready after reset", 32'(ready), 1);
        chk({done, err} == 2'b00, "R2 done/err after reset", 32'({done, err}), 0);
        chk({cr_cap_addr, cr_cap_data, cr_rd, cr_wr} == 4'b0 && cr_din == 16'h0,
            "R2 bus idle after reset", 32'({cr_cap_addr, cr_cap_data, cr_rd, cr_wr, cr_din}), 0);
        chk(rdata == 16'h0, "R2 rdata after reset", 32'(rdata), 0);

        last_rd = 16'h0;
        for (int v = 0; v < 8; v++) begin
            logic [1:0] op; logic [15:0] a, d, m;
            {op, a, d, m} = VEC[v];
            old = shadow[a[3:0]];
            d0 = done_cnt;
            run(op, a, d, m, cyc);
            chk(done && !err, "R1 command completes without error", 32'({done, err}), 2);
            if (op == 2'b01) begin
                shadow[a[3:0]] = d;
                chk(mem[a[3:0]] == d, "R6 slave holds written word", 32'(mem[a[3:0]]), 32'(d));
                chk(rdata == last_rd, "R10 rdata kept across write", 32'(rdata), 32'(last_rd));
            end else if (op == 2'b10) begin
                e = (old & ~m) | d;
                shadow[a[3:0]] = e;
                chk(rdata == old, "R7 rmw returns old value", 32'(rdata), 32'(old));
                chk(mem[a[3:0]] == e, "R7 rmw merged result stored", 32'(mem[a[3:0]]), 32'(e));
                last_rd = old;
            end else begin
                chk(rdata == old, (op == 2'b11) ? "R1 op 3 reads like op 0" : "R5 read data",
                    32'(rdata), 32'(old));
                last_rd = old;
            end
            @(negedge clk);
            chk(!done && !err, "R10 done is a single-cycle pulse", 32'({done, err}), 0);
            chk(done_cnt == d0 + 1, "R10 one done per command", 32'(done_cnt), 32'(d0 + 1));
        end
        chk(settle_bad == 0, "R3 settle before strobe", 32'(settle_bad), 0);
        chk(proto_bad == 0, "R4 four-phase handshake kept", 32'(proto_bad), 0);
        chk(rise_wr == 4, "R6 one commit per write or rmw", 32'(rise_wr), 4);

        // R9: requests during busy are ignored
        d0 = done_cnt;
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_op = 2'b01; req_addr = 16'h0002; req_wdata = 16'h0BEE; req_mask = '0;
        @(negedge clk);
        req_addr = 16'h0009; req_wdata = 16'hDEAD;
        repeat (5) @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
        repeat (3) @(negedge clk);
        chk(mem[2] == 16'h0BEE, "R9 accepted write stored", 32'(mem[2]), 32'h0BEE);
        chk(mem[9] == 16'hA009, "R9 busy request ignored", 32'(mem[9]), 32'hA009);
        chk(done_cnt == d0 + 1, "R9 no extra done", 32'(done_cnt), 32'(d0 + 1));

        // R8: acknowledge stuck low during the address phase
        mode = 1; cd0 = rise_cd; d0 = done_cnt;
        run(2'b01, 16'h0004, 16'h4444, 16'h0, cyc);
        chk(done && err, "R8 timeout flagged", 32'({done, err}), 3);
        chk(cyc >= TMO && cyc <= TMO + 10, "R8 timeout latency", 32'(cyc), 32'(TMO));
        chk({cr_cap_addr, cr_cap_data, cr_rd, cr_wr} == 4'b0 && cr_din == 16'h0,
            "R8 bus released on timeout", 32'({cr_cap_addr, cr_cap_data, cr_rd, cr_wr, cr_din}), 0);
        repeat (4) @(negedge clk);
        chk(rise_cd == cd0, "R8 no data phase after timeout", 32'(rise_cd), 32'(cd0));
        chk(mem[4] == 16'hA004, "R8 target untouched", 32'(mem[4]), 32'hA004);
        chk(done_cnt == d0 + 1, "R10 one done on timeout", 32'(done_cnt), 32'(d0 + 1));
        mode = 0;
        repeat (4) @(negedge clk);

        // R8: acknowledge stuck high after the address capture
        mode = 2; rd0 = rise_rd; ca0 = rise_ca;
        run(2'b00, 16'h1003, 16'h0, 16'h0, cyc);
        chk(done && err, "R8 release timeout flagged", 32'({done, err}), 3);
        chk(rise_ca == ca0 + 1, "R8 address strobe seen once", 32'(rise_ca), 32'(ca0 + 1));
        chk(rise_rd == rd0, "R8 no read phase after timeout", 32'(rise_rd), 32'(rd0));
        mode = 0;
        repeat (8) @(negedge clk);
        run(2'b00, 16'h1003, 16'h0, 16'h0, cyc);
        chk(done && !err, "R8 recovery read ok", 32'({done, err}), 2);
        chk(rdata == 16'h1234, "R5 read after recovery", 32'(rdata), 32'h1234);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule